// File: doc/BRIEF.md
# Debug Port Transaction Controller

This block sits between a serial wire PHY and a memory access model. The PHY hands it one decoded request at a time (access-port or debug-port select, read or write, a two-bit register address and write data). The block answers one cycle later with a three-bit acknowledge code and read data. Debug-port accesses go to a small local register set: identification, abort, control/status, wire configuration, bank select, resend and read buffer. Access-port accesses go out over a level request/acknowledge port. The outgoing address is formed from the bank selected earlier and the two request address bits.

Access-port reads are posted. A read is answered at once with the result of the previous access-port read, and it starts a new one. A read of the read buffer returns the newest completed result and starts no new access. Writes pass through a one-entry buffer, so the host can move on while a write drains. While that entry is occupied, most requests receive WAIT. After a reset or a line reset, the block answers FAULT to every request until the identification register has been read.

Top module: `dbg_port_ctrl`

## Requirements
- R1: Every cycle with `req_valid` high is followed, in the next cycle only, by `rsp_valid` high. `rsp_ack` then holds exactly one code: OK = 3'b001, WAIT = 3'b010, FAULT = 3'b100. `rsp_rdata` is the read value for an OK read and zero otherwise. Both are zero when `rsp_valid` is low.
- R2: After `rst_n` low or a `line_reset` pulse, any request other than a debug-port read at address 0 gets FAULT and changes nothing. That read returns `IDCODE_VAL` (default 32'h0BB11477), gets OK and ends the lockout.
- R3: With `req_ap` = 0, `req_addr` selects the register. 0 reads identification and writes abort. 1 is control/status when select bit 0 is 0, and wire configuration when it is 1. 2 reads resend and writes select. 3 reads the read buffer; a write there is accepted and has no effect.
- R4: A select write stores bit 0 as the address-1 selector and bits [4+BANK_W-1:4] as the bank. `ap_addr` is {bank, req_addr}.
- R5: The write buffer holds one entry. Every accepted write other than abort occupies it, and so does an accepted access-port read. While it is occupied, every request except an identification read, a control/status read or an abort write gets WAIT and changes nothing. A buffered debug-port write takes effect on the clock after acceptance and frees the entry.
- R6: `ap_req` stays high, with `ap_addr`, `ap_write` and `ap_wdata` held stable, until the clock at which `ap_ack` is high. Only one access-port operation is outstanding at a time.
- R7: An OK access-port read returns the result of the previous completed access-port read (zero after reset). A read-buffer read returns the newest completed result and raises no `ap_req`.
- R8: Control/status reads as follows. Bit 0 is the read-ok flag: 1 when the last completed access-port read had `ap_err` low. Bit 1 is a sticky error, set by any access-port completion with `ap_err` high. Bits [3:2] are the power requests, writable and driven on `pwr_req`. Bits [5:4] mirror the `pwr_ack` input. All other bits read 0.
- R9: An abort write is always accepted and never uses the buffer. Bit 2 of its data clears the sticky error; with bit 2 low the flag is kept.
- R10: A resend read returns the data of the most recent OK read other than a resend, and raises no `ap_req`.
- R11: A wire configuration write stores the low WCR_W bits and drives them on `wire_cfg`. A read returns them zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_reset | input | 1 | Line reset seen by the PHY; restores the lockout |
| req_valid | input | 1 | One-cycle request strobe |
| req_ap | input | 1 | 1 = access-port request, 0 = debug-port request |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_ack | output | 3 | Acknowledge code |
| rsp_rdata | output | 32 | Read data |
| ap_req | output | 1 | Access-port operation request, held until acknowledged |
| ap_write | output | 1 | 1 = access-port write |
| ap_addr | output | BANK_W+2 | Access-port register address |
| ap_wdata | output | 32 | Access-port write data |
| ap_ack | input | 1 | Access-port operation complete |
| ap_rdata | input | 32 | Access-port read result |
| ap_err | input | 1 | Access-port operation failed |
| pwr_ack | input | 2 | Power acknowledge bits |
| pwr_req | output | 2 | Power request bits |
| wire_cfg | output | WCR_W | Wire configuration for the PHY |

## Verification
Requests are issued back to back straight after a buffered write, so the same request is seen once while the entry is held and once after it drains. This separates the WAIT rule from the exemptions for identification, control/status and abort. Access-port reads are chained at two responder latencies. The posted value, the read-buffer value and the resend value then each differ, which shows the source of every read result. Requests made before and after a line reset, followed by an identification read, check the lockout and show that a faulted request leaves no trace. An erroring access-port read followed by aborts with and without the clear bit separates the sticky flag from the read-ok flag.

// File: rtl/dbg_port_pkg.sv
package dbg_port_pkg;

    typedef enum logic [2:0] {
        ACK_NONE  = 3'b000,
        ACK_OK    = 3'b001,
        ACK_WAIT  = 3'b010,
        ACK_FAULT = 3'b100
    } ack_e;

    typedef enum logic [3:0] {
        K_IDCODE,
        K_ABORT,
        K_CTRL_RD,
        K_CTRL_WR,
        K_WCR_RD,
        K_WCR_WR,
        K_RESEND,
        K_SEL_WR,
        K_RDBUF_RD,
        K_RDBUF_WR,
        K_AP_RD,
        K_AP_WR
    } kind_e;

    localparam int ABORT_CLR_BIT = 2;
    localparam int SEL_BANK_LSB  = 4;

endpackage

// File: rtl/dbg_req_decode.sv
module dbg_req_decode
    import dbg_port_pkg::*;
(
    input  logic       req_ap,
    input  logic       req_rnw,
    input  logic [1:0] req_addr,
    input  logic       ctrlsel,
    output kind_e      kind,
    output logic       exempt,
    output logic       buffered
);

    always_comb begin
        if (req_ap) begin
            kind = req_rnw ? K_AP_RD : K_AP_WR;
        end else begin
            unique case (req_addr)
                2'd0:    kind = req_rnw ? K_IDCODE : K_ABORT;
                2'd1:    kind = ctrlsel ? (req_rnw ? K_WCR_RD : K_WCR_WR)
                                        : (req_rnw ? K_CTRL_RD : K_CTRL_WR);
                2'd2:    kind = req_rnw ? K_RESEND : K_SEL_WR;
                default: kind = req_rnw ? K_RDBUF_RD : K_RDBUF_WR;
            endcase
        end
        exempt   = (kind == K_IDCODE) || (kind == K_CTRL_RD) || (kind == K_ABORT);
        buffered = (kind == K_CTRL_WR) || (kind == K_WCR_WR) || (kind == K_SEL_WR) ||
                   (kind == K_RDBUF_WR) || (kind == K_AP_WR) || (kind == K_AP_RD);
    end

endmodule

// File: rtl/dbg_wbuf.sv
module dbg_wbuf
    import dbg_port_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  kind_e             push_kind,
    input  logic [ADDR_W-1:0] push_addr,
    input  logic [31:0]       push_data,
    input  logic              ap_ack,
    input  logic [31:0]       ap_rdata,
    input  logic              ap_err,
    output logic              busy,
    output logic              apply_valid,
    output kind_e             apply_kind,
    output logic [31:0]       apply_data,
    output logic              done_valid,
    output logic              done_read,
    output logic [31:0]       done_data,
    output logic              done_err,
    output logic              ap_req,
    output logic              ap_write,
    output logic [ADDR_W-1:0] ap_addr,
    output logic [31:0]       ap_wdata
);

    typedef struct packed {
        logic              valid;
        kind_e             kind;
        logic [ADDR_W-1:0] addr;
        logic [31:0]       data;
    } entry_t;

    entry_t q, d;
    logic   is_ap;

    always_comb begin
        is_ap       = (q.kind == K_AP_RD) || (q.kind == K_AP_WR);
        busy        = q.valid;
        ap_req      = q.valid && is_ap;
        ap_write    = (q.kind == K_AP_WR);
        ap_addr     = q.addr;
        ap_wdata    = q.data;
        apply_valid = q.valid && !is_ap;
        apply_kind  = q.kind;
        apply_data  = q.data;
        done_valid  = ap_req && ap_ack;
        done_read   = (q.kind == K_AP_RD);
        done_data   = ap_rdata;
        done_err    = ap_err;

        d = q;
        if (apply_valid || done_valid) begin
            d.valid = 1'b0;
        end
        if (push) begin
            d.valid = 1'b1;
            d.kind  = push_kind;
            d.addr  = push_addr;
            d.data  = push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{valid: 1'b0, kind: K_IDCODE, addr: '0, data: '0};
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
    import dbg_port_pkg::*;
#(
    parameter logic [31:0] IDCODE_VAL = 32'h0BB11477,
    parameter int          BANK_W     = 4,
    parameter int          WCR_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_reset,
    input  logic                req_valid,
    input  logic                req_ap,
    input  logic                req_rnw,
    input  logic [1:0]          req_addr,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic [2:0]          rsp_ack,
    output logic [31:0]         rsp_rdata,
    output logic                ap_req,
    output logic                ap_write,
    output logic [BANK_W+1:0]   ap_addr,
    output logic [31:0]         ap_wdata,
    input  logic                ap_ack,
    input  logic [31:0]         ap_rdata,
    input  logic                ap_err,
    input  logic [1:0]          pwr_ack,
    output logic [1:0]          pwr_req,
    output logic [WCR_W-1:0]    wire_cfg
);

    localparam int ADDR_W = BANK_W + 2;

    typedef struct packed {
        logic              unlocked;
        logic              ctrlsel;
        logic [BANK_W-1:0] bank;
        logic [1:0]        pwr;
        logic [WCR_W-1:0]  wcr;
        logic              sticky;
        logic              readok;
        logic [31:0]       rdbuf;
        logic [31:0]       last;
        logic              rsp_valid;
        logic [2:0]        rsp_ack;
        logic [31:0]       rsp_data;
    } state_t;

    state_t q, d;

    kind_e             kind;
    logic              exempt;
    logic              buffered;
    logic              push;
    logic              wb_busy;
    logic              apply_valid;
    kind_e             apply_kind;
    logic [31:0]       apply_data;
    logic              done_valid;
    logic              done_read;
    logic [31:0]       done_data;
    logic              done_err;
    logic [31:0]       ctrl_word;

    dbg_req_decode u_decode (
        .req_ap   (req_ap),
        .req_rnw  (req_rnw),
        .req_addr (req_addr),
        .ctrlsel  (q.ctrlsel),
        .kind     (kind),
        .exempt   (exempt),
        .buffered (buffered)
    );

    dbg_wbuf #(.ADDR_W(ADDR_W)) u_wbuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_kind   (kind),
        .push_addr   ({q.bank, req_addr}),
        .push_data   (req_wdata),
        .ap_ack      (ap_ack),
        .ap_rdata    (ap_rdata),
        .ap_err      (ap_err),
        .busy        (wb_busy),
        .apply_valid (apply_valid),
        .apply_kind  (apply_kind),
        .apply_data  (apply_data),
        .done_valid  (done_valid),
        .done_read   (done_read),
        .done_data   (done_data),
        .done_err    (done_err),
        .ap_req      (ap_req),
        .ap_write    (ap_write),
        .ap_addr     (ap_addr),
        .ap_wdata    (ap_wdata)
    );

    always_comb begin
        ctrl_word      = '0;
        ctrl_word[0]   = q.readok;
        ctrl_word[1]   = q.sticky;
        ctrl_word[3:2] = q.pwr;
        ctrl_word[5:4] = pwr_ack;

        d           = q;
        d.rsp_valid = req_valid;
        d.rsp_ack   = ACK_NONE;
        d.rsp_data  = '0;
        push        = 1'b0;

        // a buffered debug-port write lands one clock after acceptance
        if (apply_valid) begin
            unique case (apply_kind)
                K_CTRL_WR: d.pwr = apply_data[3:2];
                K_WCR_WR:  d.wcr = apply_data[WCR_W-1:0];
                K_SEL_WR: begin
                    d.ctrlsel = apply_data[0];
                    d.bank    = apply_data[SEL_BANK_LSB +: BANK_W];
                end
                default: ;
            endcase
        end

        // completion of an access-port operation
        if (done_valid) begin
            if (done_read) begin
                d.rdbuf  = done_data;
                d.readok = !done_err;
            end
            if (done_err) begin
                d.sticky = 1'b1;
            end
        end

        if (req_valid) begin
            if (!q.unlocked && (kind != K_IDCODE)) begin
                d.rsp_ack = ACK_FAULT;
            end else if (wb_busy && !exempt) begin
                d.rsp_ack = ACK_WAIT;
            end else begin
                d.rsp_ack = ACK_OK;
                push      = buffered;
                unique case (kind)
                    K_IDCODE: begin
                        d.rsp_data = IDCODE_VAL;
                        d.unlocked = 1'b1;
                    end
                    K_ABORT: begin
                        if (req_wdata[ABORT_CLR_BIT]) begin
                            d.sticky = 1'b0;
                        end
                    end
                    K_CTRL_RD:  d.rsp_data = ctrl_word;
                    K_WCR_RD:   d.rsp_data = 32'(q.wcr);
                    K_RESEND:   d.rsp_data = q.last;
                    K_RDBUF_RD: d.rsp_data = q.rdbuf;
                    K_AP_RD:    d.rsp_data = q.rdbuf;
                    default: ;
                endcase
                if (req_rnw && (kind != K_RESEND)) begin
                    d.last = d.rsp_data;
                end
            end
        end

        if (line_reset) begin
            d.unlocked = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_valid;
    assign rsp_ack   = q.rsp_ack;
    assign rsp_rdata = q.rsp_data;
    assign pwr_req   = q.pwr;
    assign wire_cfg  = q.wcr;

endmodule

// File: rtl/dbg_port_ctrl_chk.sv
module dbg_port_ctrl_chk #(
    parameter int          ADDR_W     = 6,
    parameter logic [31:0] IDCODE_VAL = 32'h0BB11477
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_reset,
    input logic              req_valid,
    input logic              req_ap,
    input logic              req_rnw,
    input logic [1:0]        req_addr,
    input logic              rsp_valid,
    input logic [2:0]        rsp_ack,
    input logic [31:0]       rsp_rdata,
    input logic              ap_req,
    input logic              ap_ack,
    input logic              ap_write,
    input logic [ADDR_W-1:0] ap_addr,
    input logic [31:0]       ap_wdata
);

    logic is_id_rd;
    assign is_id_rd = !req_ap && req_rnw && (req_addr == 2'd0);

    // R1: a response strobe follows each request and nothing else
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R1: exactly one acknowledge code is raised
    a_r1_single_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_ack) == 1));

    // R2: lockout right after a line reset
    a_r2_fault_after_line_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(line_reset) && !line_reset && !is_id_rd) |=> (rsp_ack == 3'b100));

    // R2: identification read always answers with the parameter value
    a_r2_idcode_value: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_id_rd) |=> (rsp_ack == 3'b001 && rsp_rdata == IDCODE_VAL));

    // R6: operation held stable until acknowledged
    a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ap_req && !ap_ack) |=> (ap_req && $stable(ap_addr) && $stable(ap_write) && $stable(ap_wdata)));

endmodule

bind dbg_port_ctrl dbg_port_ctrl_chk #(
    .ADDR_W     (BANK_W + 2),
    .IDCODE_VAL (IDCODE_VAL)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_reset (line_reset),
    .req_valid  (req_valid),
    .req_ap     (req_ap),
    .req_rnw    (req_rnw),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ack    (rsp_ack),
    .rsp_rdata  (rsp_rdata),
    .ap_req     (ap_req),
    .ap_ack     (ap_ack),
    .ap_write   (ap_write),
    .ap_addr    (ap_addr),
    .ap_wdata   (ap_wdata)
);

// File: tb/dbg_port_ctrl_tb_top.sv
module dbg_port_ctrl_tb_top;

    localparam int          BANK_W = 4;
    localparam int          WCR_W  = 8;
    localparam int          ADDR_W = BANK_W + 2;
    localparam logic [31:0] IDV    = 32'h0BB11477;
    localparam logic [2:0]  OK     = 3'b001;
    localparam logic [2:0]  WT     = 3'b010;
    localparam logic [2:0]  FT     = 3'b100;
    localparam int          ERR_A  = 63;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              line_reset;
    logic              req_valid;
    logic              req_ap;
    logic              req_rnw;
    logic [1:0]        req_addr;
    logic [31:0]       req_wdata;
    logic              rsp_valid;
    logic [2:0]        rsp_ack;
    logic [31:0]       rsp_rdata;
    logic              ap_req;
    logic              ap_write;
    logic [ADDR_W-1:0] ap_addr;
    logic [31:0]       ap_wdata;
    logic              ap_ack;
    logic [31:0]       ap_rdata;
    logic              ap_err;
    logic [1:0]        pwr_ack;
    logic [1:0]        pwr_req;
    logic [WCR_W-1:0]  wire_cfg;

    dbg_port_ctrl #(.IDCODE_VAL(IDV), .BANK_W(BANK_W), .WCR_W(WCR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_reset(line_reset),
        .req_valid(req_valid), .req_ap(req_ap), .req_rnw(req_rnw),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .ap_req(ap_req), .ap_write(ap_write), .ap_addr(ap_addr), .ap_wdata(ap_wdata),
        .ap_ack(ap_ack), .ap_rdata(ap_rdata), .ap_err(ap_err),
        .pwr_ack(pwr_ack), .pwr_req(pwr_req), .wire_cfg(wire_cfg)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // reference model state
    bit          m_unl, m_csel, m_sticky, m_rdok;
    int          m_bank, m_pwr, m_wcr;
    logic [31:0] m_rdbuf, m_last;
    int          m_pend;      // 0 empty, 1 ctrl, 2 wcr, 3 sel, 4 rdbuf wr, 5 ap wr, 6 ap rd
    int          m_paddr;
    logic [31:0] m_pdata;
    bit          e_valid;
    logic [2:0]  e_ack;
    logic [31:0] e_data;

    // access-port responder
    int          lat = 2;
    int          cnt = 0;
    logic [31:0] mem [int];

    function automatic logic [31:0] mem_rd(int a);
        if (mem.exists(a)) return mem[a];
        return {16'hA5A5, 16'(a)};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(bit rv, bit ap, bit rnw, logic [1:0] a, logic [31:0] wd, bit lr);
        bit          k_ack, k_err, full, csel0, accept, exempt;
        logic [31:0] k_rd, ctrl;
        // compare outputs produced by the previous edge
        chk("R1 rsp_valid", 32'(rsp_valid), 32'(e_valid));
        chk("R1 rsp_ack", 32'(rsp_ack), 32'(e_ack));
        chk("R1 rsp_rdata", rsp_rdata, e_data);
        chk("R6 ap_req", 32'(ap_req), 32'(m_pend >= 5));
        if (m_pend >= 5) begin
            chk("R4 ap_addr", 32'(ap_addr), 32'(m_paddr));
            chk("R6 ap_write", 32'(ap_write), 32'(m_pend == 5));
            if (m_pend == 5) chk("R6 ap_wdata", ap_wdata, m_pdata);
        end
        chk("R8 pwr_req", 32'(pwr_req), 32'(m_pwr));
        chk("R11 wire_cfg", 32'(wire_cfg), 32'(m_wcr));

        // responder
        k_ack = 0; k_err = 0; k_rd = '0;
        if (ap_req) begin
            cnt++;
            if (cnt >= lat) begin
                k_ack = 1;
                k_err = (int'(ap_addr) == ERR_A);
                if (ap_write) mem[int'(ap_addr)] = ap_wdata;
                else if (!k_err) k_rd = mem_rd(int'(ap_addr));
                cnt = 0;
            end
        end

        line_reset = lr; req_valid = rv; req_ap = ap; req_rnw = rnw;
        req_addr = a; req_wdata = wd;
        ap_ack = k_ack; ap_rdata = k_rd; ap_err = k_err;

        // model: response from the state before the edge
        full  = (m_pend != 0);
        csel0 = m_csel;
        ctrl  = '0;
        ctrl[0] = m_rdok; ctrl[1] = m_sticky; ctrl[3:2] = 2'(m_pwr); ctrl[5:4] = pwr_ack;
        e_valid = rv; e_ack = 3'b000; e_data = '0; accept = 0;
        exempt = !ap && ((a == 2'd0) || (rnw && a == 2'd1 && !csel0));
        if (rv) begin
            if (!m_unl && !(!ap && rnw && a == 2'd0)) e_ack = FT;
            else if (full && !exempt) e_ack = WT;
            else begin e_ack = OK; accept = 1; end
        end

        // drain
        if (m_pend >= 1 && m_pend <= 4) begin
            if (m_pend == 1) m_pwr = int'(m_pdata[3:2]);
            if (m_pend == 2) m_wcr = int'(m_pdata[7:0]);
            if (m_pend == 3) begin m_csel = m_pdata[0]; m_bank = int'(m_pdata[7:4]); end
            m_pend = 0;
        end else if (m_pend >= 5 && k_ack) begin
            if (m_pend == 6) begin m_rdbuf = k_rd; m_rdok = !k_err; end
            if (k_err) m_sticky = 1;
            m_pend = 0;
        end

        // request effects
        if (accept) begin
            if (ap) begin
                m_pend = rnw ? 6 : 5; m_paddr = m_bank * 4 + int'(a); m_pdata = wd;
                if (rnw) e_data = m_rdbuf;
            end else begin
                case (a)
                    2'd0: if (rnw) begin e_data = IDV; m_unl = 1; end
                          else if (wd[2]) m_sticky = 0;
                    2'd1: if (rnw) e_data = csel0 ? 32'(m_wcr) : ctrl;
                          else begin m_pend = csel0 ? 2 : 1; m_pdata = wd; end
                    2'd2: if (rnw) e_data = m_last;
                          else begin m_pend = 3; m_pdata = wd; end
                    default: if (rnw) e_data = m_rdbuf;
                             else begin m_pend = 4; m_pdata = wd; end
                endcase
            end
            if (rnw && !(!ap && a == 2'd2)) m_last = e_data;
        end
        if (lr) m_unl = 0;
        @(negedge clk);
    endtask

    task automatic xfer(bit ap, bit rnw, logic [1:0] a, logic [31:0] wd);
        cyc(1, ap, rnw, a, wd, 0);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 2'd0, '0, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        rst_n = 0; line_reset = 0; req_valid = 0; req_ap = 0; req_rnw = 0;
        req_addr = 0; req_wdata = 0; ap_ack = 0; ap_rdata = 0; ap_err = 0;
        pwr_ack = 2'b10;
        m_unl = 0; m_csel = 0; m_sticky = 0; m_rdok = 0; m_bank = 0; m_pwr = 0; m_wcr = 0;
        m_rdbuf = '0; m_last = '0; m_pend = 0; m_paddr = 0; m_pdata = '0;
        e_valid = 0; e_ack = 3'b000; e_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // reset state (R1, R8, R11)
        chk("R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk("R6 reset ap_req", 32'(ap_req), 0);
        chk("R8 reset pwr_req", 32'(pwr_req), 0);
        chk("R11 reset wire_cfg", 32'(wire_cfg), 0);
        idle(1);

        // R2: lockout before identification
        xfer(0, 1, 2'd1, '0);           chk("R2 locked ctrl read", 32'(rsp_ack), 32'(FT));
        xfer(1, 0, 2'd1, 32'h1234);     chk("R2 locked ap write", 32'(rsp_ack), 32'(FT));
        idle(1);                        chk("R2 no ap_req while locked", 32'(ap_req), 0);
        xfer(0, 1, 2'd0, '0);           chk("R2 idcode data", rsp_rdata, IDV);
        chk("R2 idcode ack", 32'(rsp_ack), 32'(OK));
        xfer(0, 1, 2'd1, '0);           chk("R8 ctrl after reset", rsp_rdata, 32'h20);

        // R3, R4, R5: select write then read-buffer read while held
        xfer(0, 0, 2'd2, 32'h31);
        xfer(0, 1, 2'd3, '0);           chk("R5 wait while buffer held", 32'(rsp_ack), 32'(WT));
        xfer(0, 0, 2'd1, 32'h5A);       chk("R11 wcr write ok", 32'(rsp_ack), 32'(OK));
        xfer(0, 1, 2'd0, '0);           chk("R5 idcode exempt", 32'(rsp_ack), 32'(OK));
        xfer(0, 1, 2'd1, '0);           chk("R11 wcr readback", rsp_rdata, 32'h5A);
        chk("R11 wire_cfg", 32'(wire_cfg), 32'h5A);

        // select bank 3 with ctrl view, raise power requests
        xfer(0, 0, 2'd2, 32'h30);
        idle(1);
        xfer(0, 0, 2'd1, 32'h0C);
        idle(1);                        chk("R8 pwr_req driven", 32'(pwr_req), 3);

        // R4, R5, R6, R9: access-port write with exemptions while draining
        lat = 3;
        xfer(1, 0, 2'd1, 32'hDEAD0001); chk("R4 ap_addr bank", 32'(ap_addr), 32'h0D);
        xfer(1, 1, 2'd1, '0);           chk("R5 ap read waits", 32'(rsp_ack), 32'(WT));
        xfer(0, 1, 2'd1, '0);           chk("R5 ctrl read exempt", rsp_rdata, 32'h2C);
        xfer(0, 0, 2'd0, 32'h0);        chk("R9 abort exempt", 32'(rsp_ack), 32'(OK));
        idle(4);

        // R7: posted reads
        xfer(1, 1, 2'd1, '0);           chk("R7 posted first read", rsp_rdata, 32'h0);
        idle(5);
        xfer(0, 1, 2'd3, '0);           chk("R7 read buffer", rsp_rdata, 32'hDEAD0001);
        idle(1);                        chk("R7 rdbuf starts no access", 32'(ap_req), 0);
        xfer(0, 1, 2'd1, '0);           chk("R8 readok set", rsp_rdata, 32'h2D);
        xfer(0, 1, 2'd2, '0);           chk("R10 resend", rsp_rdata, 32'h2D);
        xfer(1, 1, 2'd2, '0);           chk("R7 posted chain", rsp_rdata, 32'hDEAD0001);
        idle(5);
        xfer(1, 1, 2'd3, '0);           chk("R7 posted chain 2", rsp_rdata, 32'hA5A5000E);
        idle(5);

        // R8, R9: error path
        xfer(0, 0, 2'd2, 32'hF0);
        idle(1);
        xfer(1, 1, 2'd3, '0);
        idle(5);
        xfer(0, 1, 2'd1, '0);           chk("R8 sticky and readok", rsp_rdata, 32'h2E);
        xfer(0, 0, 2'd0, 32'h0);
        xfer(0, 1, 2'd1, '0);           chk("R9 abort without clear", rsp_rdata, 32'h2E);
        xfer(0, 0, 2'd0, 32'h4);
        xfer(0, 1, 2'd1, '0);           chk("R9 abort clears sticky", rsp_rdata, 32'h2C);

        // R2, R10: line reset
        cyc(0, 0, 0, 2'd0, '0, 1);
        xfer(0, 1, 2'd1, '0);           chk("R2 fault after line reset", 32'(rsp_ack), 32'(FT));
        xfer(1, 1, 2'd0, '0);           chk("R2 ap read faulted", 32'(rsp_ack), 32'(FT));
        idle(1);                        chk("R2 faulted read no ap_req", 32'(ap_req), 0);
        xfer(0, 1, 2'd0, '0);           chk("R2 idcode unlocks", rsp_rdata, IDV);
        xfer(0, 1, 2'd2, '0);           chk("R10 resend idcode", rsp_rdata, IDV);

        // R3: read-buffer write has no effect
        xfer(0, 0, 2'd2, 32'h00);
        idle(1);
        xfer(0, 0, 2'd3, 32'h123);      chk("R3 rdbuf write accepted", 32'(rsp_ack), 32'(OK));
        idle(2);
        xfer(0, 1, 2'd3, '0);           chk("R3 rdbuf unchanged", rsp_rdata, 32'h0);

        // R5, R7: short latency back-to-back
        lat = 1;
        xfer(1, 0, 2'd0, 32'h11223344);
        xfer(1, 1, 2'd0, '0);           chk("R5 ap read waits lat1", 32'(rsp_ack), 32'(WT));
        xfer(1, 1, 2'd0, '0);           chk("R7 posted lat1", rsp_rdata, 32'h0);
        idle(3);
        xfer(0, 1, 2'd3, '0);           chk("R7 rdbuf lat1", rsp_rdata, 32'h11223344);
        idle(2);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

endmodule